// File: doc/BRIEF.md
# Dithered Pulse-Output Phase Accumulator Oscillator

This block is a numerically controlled oscillator for digital clock and timing synthesis. A `PHASE_W`-bit accumulator adds a frequency word on every clock and wraps modulo 2^`PHASE_W`. The mean output frequency is therefore the clock rate times freqWord / 2^`PHASE_W`. Three registered outputs come from the phase: the phase word itself, its top bit as a square wave, and a one-clock wrap pulse.

Stepping by a fixed fraction repeats with a short period, and this pattern produces spurs close to the carrier. A dither path can be switched on to break it up. A free-running maximal-length LFSR supplies a pseudo-random offset in the low `DITHER_W` bits. This offset is added to the phase only where the outputs are formed. The accumulator never sees it, so the mean frequency stays exact. When dither is off, the outputs equal the plain accumulator results bit for bit.

Top module: `nco_dither_top`

## Requirements
- R1: While rst is high at a rising edge, the accumulator clears to zero, the LFSR loads `LFSR_SEED` (default 1), and after that edge phaseOut, msbOut and pulseOut are all zero.
- R2: At every rising edge without reset, the accumulator becomes (acc + freqWord) mod 2^PHASE_W, using the freqWord present at that edge.
- R3: With ditherEn low at an edge, phaseOut after that edge equals the new accumulator value, and msbOut equals bit PHASE_W-1 of phaseOut.
- R4: With ditherEn low at an edge, pulseOut after that edge is 1 exactly when acc + freqWord reached 2^PHASE_W (the adder carried), and 0 otherwise.
- R5: With freqWord = 3·2^(PHASE_W-3) (F = 3/8) from reset, phaseOut steps through the eighths 3,6,1,4,7,2,5,0 (times 2^(PHASE_W-3)). pulseOut is high on the steps that land on 1/8, 2/8 and 0.
- R6: If F = a/b in lowest terms, phaseOut repeats every b clocks and takes b distinct values within one period (checked with F = 3/8, b = 8).
- R7: With ditherEn high at an edge, the sum T = acc + freqWord + p is formed, with p the current LFSR state zero-extended. After the edge, phaseOut = T mod 2^PHASE_W, msbOut = bit PHASE_W-1 of that value, and pulseOut = 1 exactly when T ≥ 2^PHASE_W.
- R8: Dither never changes the accumulator: after dither is switched off, phaseOut continues exactly as if dither had never been on.
- R9: The LFSR advances on every non-reset edge whatever ditherEn is, and is never zero. Its next state is (s >> 1) XOR (s[0] ? MASK : 0), with MASK = 8'hB8 for `DITHER_W` = 8.
- R10: A change of freqWord takes effect at the first rising edge at which the new value is present, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| freqWord | input | PHASE_W | Phase increment per clock |
| ditherEn | input | 1 | High: add the LFSR offset before the outputs are formed |
| phaseOut | output | PHASE_W | Registered (possibly dithered) phase word |
| msbOut | output | 1 | Square wave: top bit of phaseOut |
| pulseOut | output | 1 | High for one clock after the output sum wrapped |

## Verification
The F = 3/8 word shows the exact eighth-step order and where the wrap pulse falls, and it also gives an eight-clock period with eight distinct values. An odd word that does not divide 2^PHASE_W, the all-ones word (a wrap on almost every clock), the half-scale word (a square wave with no fraction) and the zero word (no motion and no pulse) separate errors in modular arithmetic, carry detection and msb handling. Dithered runs are compared with an independent LFSR and accumulator model, so an offset placed in the wrong bits or taken in the wrong cycle shows up. Switching dither back off, changing the word during a run, and a reset in the middle of a run then show that dither left the accumulator untouched and that a new word takes effect at once.

// File: rtl/nco_dither_pkg.sv
package nco_dither_pkg;

  // Strobes passed from control to datapath each clock.
  typedef struct packed {
    logic clearAll;   // synchronous clear of all state
    logic ditherOn;   // add dither offset on this edge
    logic lfsrStep;   // LFSR advances on this edge
  } nco_strobe_t;

  // Galois right-shift feedback masks for maximal-length sequences.
  function automatic logic [15:0] lfsrMask(input int width);
    case (width)
      4:       lfsrMask = 16'h000C;
      5:       lfsrMask = 16'h0014;
      6:       lfsrMask = 16'h0030;
      7:       lfsrMask = 16'h0060;
      8:       lfsrMask = 16'h00B8;
      9:       lfsrMask = 16'h0110;
      10:      lfsrMask = 16'h0240;
      11:      lfsrMask = 16'h0500;
      12:      lfsrMask = 16'h0E08;
      13:      lfsrMask = 16'h1C80;
      14:      lfsrMask = 16'h3802;
      15:      lfsrMask = 16'h6000;
      16:      lfsrMask = 16'hD008;
      default: lfsrMask = 16'h00B8;
    endcase
  endfunction

endpackage

// File: rtl/nco_lfsr.sv
module nco_lfsr
  import nco_dither_pkg::*;
#(
  parameter int DITHER_W  = 8,
  parameter int LFSR_SEED = 1
) (
  input  logic                clk,
  input  logic                loadSeed,
  input  logic                advance,
  output logic [DITHER_W-1:0] state
);

  localparam logic [15:0]         MASK_FULL = lfsrMask(DITHER_W);
  localparam logic [DITHER_W-1:0] MASK      = MASK_FULL[DITHER_W-1:0];
  localparam logic [DITHER_W-1:0] SEED      = LFSR_SEED[DITHER_W-1:0];

  logic [DITHER_W-1:0] stateQ;
  logic [DITHER_W-1:0] stateNext;

  always_comb begin
    stateNext = stateQ >> 1;
    if (stateQ[0]) stateNext = stateNext ^ MASK;
  end

  always_ff @(posedge clk) begin
    if (loadSeed)     stateQ <= SEED;
    else if (advance) stateQ <= stateNext;
  end

  assign state = stateQ;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (loadSeed)
    $past(loadSeed) || $past(advance) |-> stateQ != '0) else $error("lfsr zero"); // R9

  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (loadSeed)
    (!$past(loadSeed) && $past(advance)) |-> stateQ != $past(stateQ)) else $error("lfsr stuck"); // R9

endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_dither_pkg::*;
#(
  parameter int DITHER_W  = 8,
  parameter int LFSR_SEED = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ditherEn,
  output nco_strobe_t         strobe,
  output logic [DITHER_W-1:0] ditherVal
);

  logic [DITHER_W-1:0] lfsrState;

  always_comb begin
    strobe.clearAll = rst;
    strobe.ditherOn = ditherEn & ~rst;
    strobe.lfsrStep = ~rst;
  end

  nco_lfsr #(
    .DITHER_W (DITHER_W),
    .LFSR_SEED(LFSR_SEED)
  ) lfsr_i (
    .clk     (clk),
    .loadSeed(strobe.clearAll),
    .advance (strobe.lfsrStep),
    .state   (lfsrState)
  );

  assign ditherVal = strobe.ditherOn ? lfsrState : '0;

  AST_DITHER_GATED: assert property (@(posedge clk) disable iff (rst)
    !ditherEn |-> ditherVal == '0) else $error("dither leaks"); // R3

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_dither_pkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int DITHER_W = 8
) (
  input  logic                clk,
  input  nco_strobe_t         strobe,
  input  logic [PHASE_W-1:0]  freqWord,
  input  logic [DITHER_W-1:0] ditherVal,
  output logic [PHASE_W-1:0]  phaseOut,
  output logic                msbOut,
  output logic                pulseOut
);

  localparam int SUM_W = PHASE_W + 2;
  localparam int PAD_W = SUM_W - DITHER_W;

  logic [PHASE_W-1:0] accQ;
  logic [PHASE_W-1:0] accNext;
  logic [SUM_W-1:0]   outSum;
  logic [PHASE_W-1:0] phaseQ;
  logic               msbQ;
  logic               pulseQ;

  // Accumulator: state never sees the dither offset.
  assign accNext = accQ + freqWord;

  // Output adder: one wide sum so the wrap of step plus dither is one flag.
  assign outSum = {2'b00, accQ} + {2'b00, freqWord} + {{PAD_W{1'b0}}, ditherVal};

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      accQ   <= '0;
      phaseQ <= '0;
      msbQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      accQ   <= accNext;
      phaseQ <= outSum[PHASE_W-1:0];
      msbQ   <= outSum[PHASE_W-1];
      pulseQ <= |outSum[SUM_W-1:PHASE_W];
    end
  end

  assign phaseOut = phaseQ;
  assign msbOut   = msbQ;
  assign pulseOut = pulseQ;

  // Checker state: was the current / previous output formed without dither.
  logic       plainQ;
  logic       plainPrevQ;
  logic [1:0] liveQ;

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      plainQ     <= 1'b0;
      plainPrevQ <= 1'b0;
      liveQ      <= '0;
    end else begin
      plainQ     <= ~strobe.ditherOn;
      plainPrevQ <= plainQ;
      if (liveQ != 2'd3) liveQ <= liveQ + 2'd1;
    end
  end

  AST_PLAIN_EXACT: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (plainQ && liveQ != 2'd0) |-> phaseOut == accQ) else $error("plain phase != acc"); // R8

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (plainQ && plainPrevQ && liveQ >= 2'd2) |-> phaseOut == $past(phaseOut) + $past(freqWord))
    else $error("phase step wrong"); // R2

  AST_PLAIN_WRAP: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (plainQ && plainPrevQ && liveQ >= 2'd2) |-> pulseOut == (phaseOut < $past(phaseOut)))
    else $error("wrap pulse wrong"); // R4

  AST_MSB_OF_PHASE: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (liveQ != 2'd0) |-> msbOut == phaseOut[PHASE_W-1]) else $error("msb mismatch"); // R3

endmodule

// File: rtl/nco_dither_top.sv
module nco_dither_top
  import nco_dither_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int DITHER_W  = 8,
  parameter int LFSR_SEED = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               ditherEn,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               msbOut,
  output logic               pulseOut
);

  nco_strobe_t         strobe;
  logic [DITHER_W-1:0] ditherVal;

  nco_ctrl #(
    .DITHER_W (DITHER_W),
    .LFSR_SEED(LFSR_SEED)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .ditherEn (ditherEn),
    .strobe   (strobe),
    .ditherVal(ditherVal)
  );

  nco_datapath #(
    .PHASE_W (PHASE_W),
    .DITHER_W(DITHER_W)
  ) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .freqWord (freqWord),
    .ditherVal(ditherVal),
    .phaseOut (phaseOut),
    .msbOut   (msbOut),
    .pulseOut (pulseOut)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (phaseOut == '0 && !msbOut && !pulseOut)) else $error("reset state"); // R1

endmodule

// File: tb/nco_dither_top_tb.sv
`timescale 1ns/1ps
module nco_dither_top_tb_top;

  localparam int PW = 16;
  localparam int DW = 8;
  localparam logic [DW-1:0] MASK = 8'hB8;
  localparam logic [PW-1:0] EIGHTH = 16'h2000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] freqWord = '0;
  logic          ditherEn = 1'b0;
  logic [PW-1:0] phaseOut;
  logic          msbOut;
  logic          pulseOut;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  always #2 clk = ~clk;   // 250 MHz

  nco_dither_top #(.PHASE_W(PW), .DITHER_W(DW), .LFSR_SEED(1)) dut_i (
    .clk(clk), .rst(rst), .freqWord(freqWord), .ditherEn(ditherEn),
    .phaseOut(phaseOut), .msbOut(msbOut), .pulseOut(pulseOut)
  );

  // Behavioural reference model, plain integers.
  longint mAcc = 0, mPhase = 0, mLfsr = 1;
  bit     mPulse = 0;
  localparam longint MOD = 64'd1 << PW;

  always @(posedge clk) begin
    if (rst) begin
      mAcc = 0; mPhase = 0; mPulse = 0; mLfsr = 1;
    end else begin
      longint p, t;
      p = ditherEn ? mLfsr : 0;
      t = mAcc + longint'(freqWord) + p;
      mPhase = t % MOD;
      mPulse = (t >= MOD);
      mAcc = (mAcc + longint'(freqWord)) % MOD;
      if (mLfsr[0]) mLfsr = (mLfsr >> 1) ^ longint'(MASK);
      else          mLfsr = mLfsr >> 1;
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  bit compareOn = 1'b1;
  always @(negedge clk) begin
    if (compareOn && !finished) begin
      chk(curTag, "phaseOut", longint'(phaseOut), mPhase);
      chk(curTag, "msbOut",   longint'(msbOut),   (mPhase >> (PW-1)) & 1);
      chk(curTag, "pulseOut", longint'(pulseOut), longint'(mPulse));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    longint seen[9];
    run(3);
    // R1: reset state
    chk("R1", "reset phase", longint'(phaseOut), 0);
    chk("R1", "reset pulse", longint'(pulseOut), 0);

    // R5 / R6: F = 3/8 exact sequence
    curTag = "R5";
    freqWord = 3 * EIGHTH;
    rst = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      longint eighth, prevE;
      run(1);
      eighth = (3 * i) % 8;
      prevE  = (3 * (i - 1)) % 8;
      chk("R5", "eighth step", longint'(phaseOut), eighth * EIGHTH);
      chk("R5", "wrap pulse",  longint'(pulseOut), (eighth < prevE) ? 1 : 0);
      seen[i-1] = longint'(phaseOut);
    end
    // R6: period 8, eight distinct values
    begin
      int distinct = 0;
      for (int a = 0; a < 8; a++) begin
        bit dup = 0;
        for (int b = 0; b < a; b++) if (seen[a] == seen[b]) dup = 1;
        if (!dup) distinct++;
      end
      chk("R6", "distinct values", distinct, 8);
      chk("R6", "period repeat", seen[8], seen[0]);
    end

    // R2 / R4 / R10: other words, changed mid-run
    curTag = "R2";  freqWord = 16'h1235; run(40);
    curTag = "R10"; freqWord = 16'hFFFF; run(1);
    chk("R10", "new word at once", longint'(phaseOut), mPhase);
    curTag = "R4";  run(20);
    curTag = "R3";  freqWord = 16'h8000; run(12);
    curTag = "R2";  freqWord = 16'h0000; run(6);
    chk("R4", "no pulse for zero word", longint'(pulseOut), 0);

    // R7 / R9: dither on
    curTag = "R7"; freqWord = 3 * EIGHTH; ditherEn = 1'b1; run(60);
    curTag = "R9"; freqWord = 16'h00F1; run(300);

    // R8: dither off resumes the undithered sequence
    curTag = "R8"; ditherEn = 1'b0; run(1);
    chk("R8", "acc untouched by dither", longint'(phaseOut), mAcc);
    run(20);

    // R1: reset in the middle of a dithered run
    curTag = "R7"; ditherEn = 1'b1; freqWord = 16'hABCD; run(25);
    curTag = "R1"; rst = 1'b1; run(2);
    chk("R1", "mid-run reset phase", longint'(phaseOut), 0);
    rst = 1'b0; curTag = "R9"; run(30);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule